// File: doc/BRIEF.md
# Instruction Line MAC Verifier

This block checks the integrity of one freshly filled instruction-cache line. The line arrives as a run of 128-bit words. Every word except the last is message text. The last word is the stored tag. The words are absorbed into a keyed chain, one per cycle: each word is XORed with the current chain value and passed through one keyed round. The final chain value then goes through a fixed 14-round finishing pipeline. The result is compared with the stored tag over a selectable number of low-order bits.

While the check runs, the processor goes on executing the line speculatively. The block reports the outcome with a done pulse, a held pass flag and a one-cycle fail pulse. On a pass it records a safe-to-execute bit for the line's cache entry, and the processor can read that bit through a registered query port. The key sits in an internal register loaded at reset and is never driven onto any port. Only one line is checked at a time. A start that arrives while a check is running is refused.

The round used here is a stand-in keyed permutation, not a real cipher. It keeps the latency figure: 14 cycles plus one cycle per line word.

Top module: `mac_line_verifier`

## Requirements
- R1: After reset, busy, done, pass and fail are 0 and the safe bit of every line reads 0.
- R2: Let F(x,r) = rotl(x XOR K, 7) XOR {16{r XOR 8'hA5}}, where K is the key and r is an 8-bit round index. The chain starts at zero and takes c = F(c XOR w_i, 0) for every message word w_0..w_(N-2). The MAC is then F(...F(F(c,1),2)...,14).
- R3: Words are taken only on cycles with word_valid high. The word sampled with an accepted start is word 0, and word N-1 is the tag, with N = line bytes × 8 / 128 (16 by default). With back-to-back words, done rises exactly 14+N clock edges after the accepting edge. Each idle word cycle adds one edge.
- R4: Only the low TAG_BITS bits (64 by default) of the MAC and the tag are compared. A difference at bit TAG_BITS or above still passes, and a difference at bit TAG_BITS-1 or bit 0 fails.
- R5: done and fail are one-cycle pulses, and fail is high only together with done. pass rises with done on a match and holds until the next accepted start.
- R6: On a pass, the safe bit of the line id given with the accepted start becomes 1. An accepted start clears the safe bit of its own id, so after a fail that bit stays 0.
- R7: busy is high from the accepting edge until the edge that raises done. A start while busy is refused: it does not change the result being computed and does not clear any safe bit.
- R8: query_safe shows the safe bit of query_id one edge after it is sampled. When that bit is written on the same edge, query_safe shows the old value.
- R9: word_valid while idle has no effect: busy and done stay 0, and a later line verifies normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin checking a line (taken only when not busy) |
| start_id | input | ID_W | Cache entry index of the line |
| word_valid | input | 1 | A line word is present on word_data |
| word_data | input | 128 | Line word; the last word of the line is the tag |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last check matched; held until next start |
| fail | output | 1 | One-cycle mismatch pulse |
| query_id | input | ID_W | Entry whose safe bit is read |
| query_safe | output | 1 | Registered safe-to-execute bit of query_id |

## Verification
Two functions can act on the same edge: writing a line's safe bit when its check completes, and reading that same bit through the query port. The bench holds query_id on the line under check for the whole run. It expects the old value (0, cleared by the start) in the done cycle and the new value one cycle later. A second overlap is a refused start that arrives mid-line together with a valid word. It is judged by the completed MAC being unchanged and by the earlier safe bit of the refused id still reading 1.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int WORD_W = 128;
  localparam int ROT    = 7;

  function automatic logic [WORD_W-1:0] mac_round(input logic [WORD_W-1:0] x,
                                                  input logic [WORD_W-1:0] k,
                                                  input logic [7:0]        r);
    logic [WORD_W-1:0] t;
    t = x ^ k;
    return {t[WORD_W-1-ROT:0], t[WORD_W-1:WORD_W-ROT]} ^ {(WORD_W/8){r ^ 8'hA5}};
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_ABSORB, ST_WAIT} chain_st_t;
endpackage

// File: rtl/mac_chain.sv
module mac_chain
  import mac_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int ID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] key,
  input  logic              start,
  input  logic [ID_W-1:0]   start_id,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              fin,
  output logic              busy,
  output logic              accept,
  output logic              launch,
  output logic [WORD_W-1:0] chain_out,
  output logic [WORD_W-1:0] tag_out,
  output logic [ID_W-1:0]   id_out
);
  localparam int IDX_W = $clog2(WORDS);

  chain_st_t         st_q;
  logic [WORD_W-1:0] chain_q, tag_q, base_chain;
  logic [IDX_W-1:0]  idx_q, base_idx;
  logic [ID_W-1:0]   id_q;
  logic              launch_q, take, last;

  always_comb begin
    accept     = start && (st_q == ST_IDLE);
    take       = word_valid && (accept || (st_q == ST_ABSORB));
    base_chain = accept ? '0 : chain_q;
    base_idx   = accept ? '0 : idx_q;
    last       = (base_idx == IDX_W'(WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      chain_q  <= '0;
      tag_q    <= '0;
      idx_q    <= '0;
      id_q     <= '0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      if (accept) begin
        id_q    <= start_id;
        chain_q <= '0;
        idx_q   <= '0;
        st_q    <= ST_ABSORB;
      end
      if (take) begin
        if (last) begin
          tag_q    <= word_data;
          launch_q <= 1'b1;
          st_q     <= ST_WAIT;
        end else begin
          chain_q <= mac_round(base_chain ^ word_data, key, 8'd0);
          idx_q   <= base_idx + IDX_W'(1);
        end
      end
      if (st_q == ST_WAIT && fin) st_q <= ST_IDLE;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign launch    = launch_q;
  assign chain_out = chain_q;
  assign tag_out   = tag_q;
  assign id_out    = id_q;
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe
  import mac_pkg::*;
#(
  parameter int DEPTH = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] key,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_data
);
  logic [WORD_W-1:0] data [DEPTH+1];
  logic              vld  [DEPTH+1];

  assign data[0] = in_data;
  assign vld[0]  = in_vld;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[s+1]  <= 1'b0;
        data[s+1] <= '0;
      end else begin
        vld[s+1] <= vld[s];
        if (vld[s]) data[s+1] <= mac_round(data[s], key, 8'(s + 1));
      end
    end
  end

  assign out_vld  = vld[DEPTH];
  assign out_data = data[DEPTH];
endmodule

// File: rtl/safe_flags.sv
module safe_flags #(
  parameter int LINES = 16,
  parameter int ID_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic            set_en,
  input  logic [ID_W-1:0] set_id,
  input  logic [ID_W-1:0] rd_id,
  output logic            rd_q
);
  logic [LINES-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= flag_q[rd_id];
      if (clr_en) flag_q[clr_id] <= 1'b0;
      if (set_en) flag_q[set_id] <= 1'b1;
    end
  end
endmodule

// File: rtl/mac_line_verifier.sv
module mac_line_verifier
  import mac_pkg::*;
#(
  parameter int              LINE_BYTES   = 256,
  parameter int              TAG_BITS     = 64,
  parameter int              LINES        = 16,
  parameter int              CIPHER_DEPTH = 14,
  parameter logic [127:0]    SECRET_KEY   = 128'h3C6E_F372_A54F_F53A_510E_527F_9B05_688C,
  localparam int             WORDS        = LINE_BYTES * 8 / WORD_W,
  localparam int             ID_W         = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ID_W-1:0]   start_id,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  input  logic [ID_W-1:0]   query_id,
  output logic              query_safe
);
  localparam logic [WORD_W-1:0] CMP_MASK =
    (TAG_BITS >= WORD_W) ? '1 : ((WORD_W'(1) << TAG_BITS) - WORD_W'(1));

  logic [WORD_W-1:0] key_q;
  logic              accept, launch, fin, match;
  logic [WORD_W-1:0] chain_v, tag_v, mac_v;
  logic [ID_W-1:0]   id_v;
  logic              done_q, pass_q, fail_q;

  always_ff @(posedge clk) begin
    if (rst) key_q <= SECRET_KEY;
  end

  mac_chain #(.WORDS(WORDS), .ID_W(ID_W)) u_chain (
    .clk(clk), .rst(rst), .key(key_q), .start(start), .start_id(start_id),
    .word_valid(word_valid), .word_data(word_data), .fin(fin), .busy(busy),
    .accept(accept), .launch(launch), .chain_out(chain_v), .tag_out(tag_v),
    .id_out(id_v)
  );

  mac_pipe #(.DEPTH(CIPHER_DEPTH)) u_pipe (
    .clk(clk), .rst(rst), .key(key_q), .in_vld(launch), .in_data(chain_v),
    .out_vld(fin), .out_data(mac_v)
  );

  assign match = (((mac_v ^ tag_v) & CMP_MASK) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= fin;
      fail_q <= fin && !match;
      if (fin)         pass_q <= match;
      else if (accept) pass_q <= 1'b0;
    end
  end

  safe_flags #(.LINES(LINES), .ID_W(ID_W)) u_flags (
    .clk(clk), .rst(rst), .clr_en(accept), .clr_id(start_id),
    .set_en(fin && match), .set_id(id_v), .rd_id(query_id), .rd_q(query_safe)
  );

  assign done = done_q;
  assign pass = pass_q;
  assign fail = fail_q;
endmodule

// File: rtl/mac_line_verifier_chk.sv
module mac_line_verifier_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic pass,
  input logic fail
);
  // R5
  fail_pulse_chk: assert property (@(posedge clk) disable iff (rst) fail |=> !fail);
  // R5
  fail_done_chk: assert property (@(posedge clk) disable iff (rst) fail |-> done);
  // R5
  pass_fail_chk: assert property (@(posedge clk) disable iff (rst) !(pass && fail));
  // R5
  pass_hold_chk: assert property (@(posedge clk) disable iff (rst) (pass && !start) |=> pass);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
endmodule

bind mac_line_verifier mac_line_verifier_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .pass(pass), .fail(fail)
);

// File: tb/test_mac_line_verifier.sv
module test_mac_line_verifier;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 16;
  localparam int TAGB  = 64;
  localparam int LINES = 16;
  localparam logic [127:0] K = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic clk = 0, rst = 1, start = 0, word_valid = 0, busy, done, pass, fail, query_safe;
  logic [3:0] start_id = 0, query_id = 0;
  logic [127:0] word_data = 0;
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit exp_flag [LINES];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_line_verifier #(.SECRET_KEY(K)) i_mac_line_verifier (
    .clk(clk), .rst(rst), .start(start), .start_id(start_id), .word_valid(word_valid),
    .word_data(word_data), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .query_id(query_id), .query_safe(query_safe)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] f_rnd(input logic [127:0] x, input logic [7:0] r);
    logic [127:0] t = x ^ K;
    return ((t << 7) | (t >> 121)) ^ {16{r ^ 8'hA5}};
  endfunction

  task automatic run_line(input int id, input int mode, input int gaps, input bit refuse);
    logic [127:0] w [N];
    logic [127:0] c, flip;
    bit exp_pass;
    int s, t, lat;
    c = '0;
    for (int i = 0; i < N - 1; i++) begin
      w[i] = {32'(id * 7 + 1), 32'(i), ~32'(id * 13 + i), 32'(i) ^ 32'h9E37_79B9};
      c = f_rnd(c ^ w[i], 8'd0);
    end
    for (int r = 1; r <= 14; r++) c = f_rnd(c, 8'(r));
    case (mode)
      1: flip = 128'd1 << 127;
      2: flip = 128'd1;
      3: flip = 128'd1 << (TAGB - 1);
      4: flip = 128'd1 << TAGB;
      default: flip = '0;
    endcase
    w[N-1] = c ^ flip;
    exp_pass = (mode == 0 || mode == 1 || mode == 4);

    @(negedge clk);
    query_id = 4'(id);
    start = 1; start_id = 4'(id); word_valid = 1; word_data = w[0];
    s = cyc + 1;
    for (int k = 1; k < N; k++) begin
      if (k == 2) for (int g = 0; g < gaps; g++) begin
        @(negedge clk); start = 0; word_valid = 0;
      end
      @(negedge clk);
      start = refuse && (k == 3); start_id = 4'd0;
      word_valid = 1; word_data = w[k];
    end
    @(negedge clk); start = 0; word_valid = 0;
    t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    lat = cyc - s;
    chk(lat == 14 + N + gaps, "R3 latency", 128'(lat), 128'(14 + N + gaps));
    chk(pass == exp_pass, "R2/R4 pass", 128'(pass), 128'(exp_pass));
    chk(fail == !exp_pass, "R4 fail", 128'(fail), 128'(!exp_pass));
    chk(busy == 0, "R7 busy at done", 128'(busy), 128'd0);
    chk(query_safe == 0, "R8 old value on write edge", 128'(query_safe), 128'd0);
    exp_flag[id] = exp_pass;
    @(negedge clk);
    chk(done == 0 && fail == 0, "R5 pulses", {done, fail}, 128'd0);
    chk(query_safe == exp_pass, "R6 safe bit", 128'(query_safe), 128'(exp_pass));
    repeat (2) @(negedge clk);
    chk(pass == exp_pass, "R5 pass held", 128'(pass), 128'(exp_pass));
    if (refuse) begin
      query_id = 4'd0;
      @(negedge clk);
      chk(query_safe == exp_flag[0], "R7 refused start kept bit", 128'(query_safe), 128'(exp_flag[0]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({busy, done, pass, fail} == 4'b0, "R1 outputs", 128'({busy, done, pass, fail}), 128'd0);
    for (int q = 0; q < LINES; q++) begin
      query_id = 4'(q);
      @(negedge clk);
      chk(query_safe == 0, "R1 safe bit", 128'(query_safe), 128'd0);
    end
    for (int k = 0; k < 5; k++) begin
      word_valid = 1; word_data = {4{32'hDEAD_0000 + 32'(k)}};
      @(negedge clk);
      chk(busy == 0 && done == 0, "R9 idle words", {busy, done}, 128'd0);
    end
    word_valid = 0;
    for (int id = 0; id < LINES; id++)
      run_line(id, id % 5, id % 3, (id >= 2) && (id % 2 == 0));
    run_line(5, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule